// File: doc/BRIEF.md
# Variable-Width Banked Stack Engine

This block moves a register value between a datapath and a byte-wide stack memory, one byte per clock. A single start strobe selects a direction, push or pull, and carries a size operand that sets how many bytes of the 64-bit value take part. The operand is clamped into the range 1 to 8. The stack address combines a per-thread bank value, which sits in the upper address bits, with a 16-bit stack pointer. The pointer moves by one for every byte transferred.

A push writes the selected bytes starting with the most significant one. It writes each byte at the current pointer and then steps the pointer down. A pull steps the pointer up before each read. The first byte it fetches lands in the lowest byte of the result, and each later byte lands one position higher. Result bytes that were not fetched read as zero. The engine drives a synchronous byte memory port with one access per cycle. It reports the updated pointer and the assembled value, and it pulses done for one cycle when the transfer is finished.

Top module: `stk_engine`

## Requirements
- R1: Every memory access uses address bits [23:16] equal to the bank sampled at start and bits [15:0] equal to the 16-bit pointer used for that byte.
- R2: The byte count n follows the size operand read as a signed byte: values from 1 to 8 give that count, values above 8 give 8, and zero or negative values give 1.
- R3: A push (dir=0) performs exactly n writes. The first write is at the starting pointer and carries byte n-1 of the source, where byte k is bits [8k+7:8k]. Each following write is one address lower and carries the next lower byte. The pointer decrements after each write, so it ends at start-n.
- R4: A pull (dir=1) performs exactly n reads. Each read is at the pointer plus one, and the pointer takes that value. The first byte read becomes byte 0 of the result, and later bytes fill bytes 1, 2 and upward. The pointer ends at start+n.
- R5: Result bytes n through 7 of a pull are zero, whatever an earlier pull left there.
- R6: The pointer wraps modulo 2^16 in both directions and never changes the bank bits of the address.
- R7: done is high for exactly one cycle. For a push it is visible n+1 cycles after the cycle in which start is presented, and for a pull it is visible n+2 cycles after. The pointer and result outputs are final when done is high.
- R8: A start is taken only when the engine is idle. A start presented between acceptance and the done cycle, inclusive, has no effect on the transfer in progress.
- R9: No cycle issues both a write and a read, and no access is issued while the engine is idle.
- R10: After reset, done, mem_we and mem_re are low, and sp_out and pull_data are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| dir | input | 1 | 0 = push, 1 = pull |
| size | input | 8 | Signed byte-count operand, clamped to 1..8 |
| src_data | input | 64 | Value to push |
| bank | input | 8 | Stack bank, upper address bits |
| sp_in | input | 16 | Starting stack pointer |
| mem_we | output | 1 | Byte write strobe |
| mem_re | output | 1 | Byte read strobe (data returns next cycle) |
| mem_addr | output | 24 | Byte address {bank, pointer} |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte returned by the memory one cycle after mem_re |
| sp_out | output | 16 | Current (updated) stack pointer |
| pull_data | output | 64 | Assembled pulled value |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situations to reach are a pull of fewer bytes than the pull before it, which leaves stale upper bytes that must be cleared, and a transfer whose pointer crosses 0x0000/0xFFFF without touching the bank. The stimulus sweeps all 256 size operands against starting pointers placed at and next to the wrap point. Each push is followed by a pull that restores the pointer, and the sizes alternate in magnitude through the sweep, so stale upper bytes appear repeatedly. Some transfers also receive a second start, with different parameters, while they are busy.

// File: rtl/stk_pkg.sv
package stk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_XFER  = 2'd1,
        ST_DRAIN = 2'd2,
        ST_DONE  = 2'd3
    } stk_state_e;

    typedef enum logic {
        DIR_PUSH = 1'b0,
        DIR_PULL = 1'b1
    } stk_dir_e;

    // Pull capture tag: a read issued last cycle returns data now
    typedef struct packed {
        logic       vld;
        logic [7:0] lane;
    } stk_cap_t;

    // Byte-count clamp: non-positive -> 1, above max -> max
    function automatic int stk_clamp_len(input int sz, input int max_n);
        if (sz <= 0)
            return 1;
        else if (sz > max_n)
            return max_n;
        else
            return sz;
    endfunction

endpackage

// File: rtl/stk_len_clamp.sv
module stk_len_clamp
    import stk_pkg::*;
#(
    parameter int SIZE_W = 8,
    parameter int NBYTES = 8,
    parameter int CNT_W  = 4
) (
    input  logic [SIZE_W-1:0] size_i,
    output logic [CNT_W-1:0]  cnt_o
);

    int sz_ext;

    always_comb begin
        sz_ext = int'($signed(size_i));
        cnt_o  = CNT_W'(stk_clamp_len(sz_ext, NBYTES));
    end

endmodule

// File: rtl/stk_ptr.sv
module stk_ptr #(
    parameter int SP_W   = 16,
    parameter int BANK_W = 8,
    parameter int ADDR_W = SP_W + BANK_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [SP_W-1:0]   sp_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic              dec_i,
    input  logic              inc_i,
    output logic [SP_W-1:0]   sp_o,
    output logic [ADDR_W-1:0] push_addr_o,
    output logic [ADDR_W-1:0] pull_addr_o
);

    logic [SP_W-1:0]   sp_q;
    logic [BANK_W-1:0] bank_q;
    logic [SP_W-1:0]   sp_up;
    logic [SP_W-1:0]   sp_dn;

    // Pointer arithmetic stays inside SP_W bits: wrap, never carry into bank
    assign sp_up = sp_q + SP_W'(1);
    assign sp_dn = sp_q - SP_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_q   <= '0;
            bank_q <= '0;
        end else if (load_i) begin
            sp_q   <= sp_i;
            bank_q <= bank_i;
        end else if (dec_i) begin
            sp_q   <= sp_dn;
        end else if (inc_i) begin
            sp_q   <= sp_up;
        end
    end

    assign sp_o        = sp_q;
    assign push_addr_o = {bank_q, sp_q};
    assign pull_addr_o = {bank_q, sp_up};

endmodule

// File: rtl/stk_lanes.sv
module stk_lanes
    import stk_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int NBYTES = DATA_W / 8,
    parameter int IDX_W  = $clog2(NBYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [IDX_W-1:0]  sel_lane_i,
    input  stk_cap_t          cap_i,
    input  logic [7:0]        rdata_i,
    output logic [7:0]        wbyte_o,
    output logic [DATA_W-1:0] value_o
);

    logic [7:0] src_b [NBYTES];
    logic [7:0] val_b [NBYTES];

    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        // Source byte held for the whole push
        always_ff @(posedge clk) begin
            if (rst)
                src_b[g] <= '0;
            else if (load_i)
                src_b[g] <= data_i[8*g +: 8];
        end

        // Result byte: cleared on each new transfer, filled by its own read
        always_ff @(posedge clk) begin
            if (rst || load_i)
                val_b[g] <= '0;
            else if (cap_i.vld && (cap_i.lane == 8'(g)))
                val_b[g] <= rdata_i;
        end

        assign value_o[8*g +: 8] = val_b[g];
    end

    assign wbyte_o = src_b[sel_lane_i];

endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
    import stk_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  stk_dir_e         dir_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             accept_o,
    output logic             busy_o,
    output stk_dir_e         dir_o,
    output logic             we_o,
    output logic             re_o,
    output logic [IDX_W-1:0] lane_o,
    output stk_cap_t         cap_o,
    output logic             done_o
);

    stk_state_e       state_q;
    stk_dir_e         dir_q;
    logic [CNT_W-1:0] remain_q;
    logic [IDX_W-1:0] lane_q;
    stk_cap_t         cap_q;
    logic             xfer;
    logic             last;

    assign accept_o = (state_q == ST_IDLE) && start_i;
    assign xfer     = (state_q == ST_XFER);
    assign last     = (remain_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            dir_q    <= DIR_PUSH;
            remain_q <= '0;
            lane_q   <= '0;
            cap_q    <= '0;
        end else begin
            cap_q.vld  <= xfer && (dir_q == DIR_PULL);
            cap_q.lane <= 8'(lane_q);
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        dir_q    <= dir_i;
                        remain_q <= cnt_i;
                        lane_q   <= (dir_i == DIR_PUSH) ? IDX_W'(cnt_i - CNT_W'(1)) : '0;
                        state_q  <= ST_XFER;
                    end
                end
                ST_XFER: begin
                    remain_q <= remain_q - CNT_W'(1);
                    lane_q   <= (dir_q == DIR_PUSH) ? lane_q - IDX_W'(1) : lane_q + IDX_W'(1);
                    if (last)
                        state_q <= (dir_q == DIR_PUSH) ? ST_DONE : ST_DRAIN;
                end
                ST_DRAIN: state_q <= ST_DONE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o = (state_q != ST_IDLE);
    assign dir_o  = dir_q;
    assign we_o   = xfer && (dir_q == DIR_PUSH);
    assign re_o   = xfer && (dir_q == DIR_PULL);
    assign lane_o = lane_q;
    assign cap_o  = cap_q;
    assign done_o = (state_q == ST_DONE);

endmodule

// File: rtl/stk_engine.sv
module stk_engine
    import stk_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int SP_W   = 16,
    parameter int BANK_W = 8,
    parameter int SIZE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic                     dir,
    input  logic [SIZE_W-1:0]        size,
    input  logic [DATA_W-1:0]        src_data,
    input  logic [BANK_W-1:0]        bank,
    input  logic [SP_W-1:0]          sp_in,
    output logic                     mem_we,
    output logic                     mem_re,
    output logic [SP_W+BANK_W-1:0]   mem_addr,
    output logic [7:0]               mem_wdata,
    input  logic [7:0]               mem_rdata,
    output logic [SP_W-1:0]          sp_out,
    output logic [DATA_W-1:0]        pull_data,
    output logic                     done
);

    localparam int NBYTES = DATA_W / 8;
    localparam int CNT_W  = $clog2(NBYTES + 1);
    localparam int IDX_W  = $clog2(NBYTES);
    localparam int ADDR_W = SP_W + BANK_W;

    logic [CNT_W-1:0]  cnt;
    logic              accept;
    logic              busy;
    stk_dir_e          dir_q;
    logic              we;
    logic              re;
    logic [IDX_W-1:0]  lane;
    stk_cap_t          cap;
    logic [ADDR_W-1:0] push_addr;
    logic [ADDR_W-1:0] pull_addr;

    stk_len_clamp #(
        .SIZE_W (SIZE_W),
        .NBYTES (NBYTES),
        .CNT_W  (CNT_W)
    ) u_len (
        .size_i (size),
        .cnt_o  (cnt)
    );

    stk_ctrl #(
        .CNT_W (CNT_W),
        .IDX_W (IDX_W)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start),
        .dir_i    (stk_dir_e'(dir)),
        .cnt_i    (cnt),
        .accept_o (accept),
        .busy_o   (busy),
        .dir_o    (dir_q),
        .we_o     (we),
        .re_o     (re),
        .lane_o   (lane),
        .cap_o    (cap),
        .done_o   (done)
    );

    stk_ptr #(
        .SP_W   (SP_W),
        .BANK_W (BANK_W),
        .ADDR_W (ADDR_W)
    ) u_ptr (
        .clk         (clk),
        .rst         (rst),
        .load_i      (accept),
        .sp_i        (sp_in),
        .bank_i      (bank),
        .dec_i       (we),
        .inc_i       (re),
        .sp_o        (sp_out),
        .push_addr_o (push_addr),
        .pull_addr_o (pull_addr)
    );

    stk_lanes #(
        .DATA_W (DATA_W),
        .NBYTES (NBYTES),
        .IDX_W  (IDX_W)
    ) u_lanes (
        .clk        (clk),
        .rst        (rst),
        .load_i     (accept),
        .data_i     (src_data),
        .sel_lane_i (lane),
        .cap_i      (cap),
        .rdata_i    (mem_rdata),
        .wbyte_o    (mem_wdata),
        .value_o    (pull_data)
    );

    assign mem_we   = we;
    assign mem_re   = re;
    assign mem_addr = re ? pull_addr : push_addr;

endmodule

// File: rtl/stk_engine_chk.sv
module stk_engine_chk #(
    parameter int SP_W = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic            busy,
    input logic            dir_q,
    input logic            mem_we,
    input logic            mem_re,
    input logic [15:0]     mem_addr_lo,
    input logic [SP_W-1:0] sp_out,
    input logic            done
);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R7

    AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re)); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(mem_we || mem_re)); // R9

    AST_PUSH_DECR: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> sp_out == ($past(sp_out) - SP_W'(1))); // R3

    AST_PULL_INCR: assert property (@(posedge clk) disable iff (rst)
        mem_re |=> sp_out == ($past(sp_out) + SP_W'(1))); // R4

    AST_PULL_PREINC: assert property (@(posedge clk) disable iff (rst)
        mem_re |=> mem_addr_lo == 16'($past(mem_addr_lo) + 16'(1)) || !mem_re); // R6

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(dir_q)); // R8

endmodule

bind stk_engine stk_engine_chk #(.SP_W(SP_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .busy        (busy),
    .dir_q       (dir_q),
    .mem_we      (mem_we),
    .mem_re      (mem_re),
    .mem_addr_lo (mem_addr[15:0]),
    .sp_out      (sp_out),
    .done        (done)
);

// File: tb/stk_engine_tb.sv
module stk_engine_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        dir;
    logic [7:0]  size;
    logic [63:0] src_data;
    logic [7:0]  bank;
    logic [15:0] sp_in;
    logic        mem_we;
    logic        mem_re;
    logic [23:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic [15:0] sp_out;
    logic [63:0] pull_data;
    logic        done;

    int total = 0;
    int bad   = 0;

    logic [7:0] mem [int];
    int   wr_seen = 0;
    int   rd_seen = 0;
    int   bank_err = 0;
    logic [7:0] cur_bank = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stk_engine u_dut (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .dir       (dir),
        .size      (size),
        .src_data  (src_data),
        .bank      (bank),
        .sp_in     (sp_in),
        .mem_we    (mem_we),
        .mem_re    (mem_re),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .sp_out    (sp_out),
        .pull_data (pull_data),
        .done      (done)
    );

    function automatic logic [7:0] mem_rd(input int a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    // Byte memory model with one-cycle read latency
    always @(posedge clk) begin
        if (mem_we) begin
            mem[int'(mem_addr)] = mem_wdata;
            wr_seen++;
            if (mem_addr[23:16] != cur_bank) bank_err++;
        end
        if (mem_re) begin
            mem_rdata <= mem_rd(int'(mem_addr));
            rd_seen++;
            if (mem_addr[23:16] != cur_bank) bank_err++;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int exp_len(input logic [7:0] s);
        int v = int'($signed(s));
        if (v <= 0) return 1;
        if (v > 8) return 8;
        return v;
    endfunction

    task automatic run_op(input bit pull, input logic [7:0] sz, input logic [63:0] d,
                          input logic [7:0] bk, input logic [15:0] sp0, input bit inject);
        int n = exp_len(sz);
        int w0, r0, b0, k;
        logic [63:0] mask, got;
        n    = exp_len(sz);
        mask = (n == 8) ? '1 : ((64'd1 << (8*n)) - 64'd1);
        @(negedge clk);
        w0 = wr_seen; r0 = rd_seen; b0 = bank_err;
        cur_bank = bk;
        start = 1'b1; dir = pull; size = sz; src_data = d; bank = bk; sp_in = sp0;
        k = 0;
        do begin
            @(negedge clk);
            k++;
            if (inject && k == 1) begin
                // R8: second start while busy with different parameters
                start = 1'b1; dir = ~pull; size = 8'd3; src_data = ~d; sp_in = ~sp0; bank = ~bk;
            end else begin
                start = 1'b0;
            end
        end while (!done && k < 40);
        start = 1'b0;
        chk(k == (pull ? n + 2 : n + 1), "R7 latency", 64'(k), 64'(pull ? n + 2 : n + 1));
        if (pull) begin
            chk(sp_out == 16'(sp0 + 16'(n)), "R4/R6 pointer after pull", 64'(sp_out), 64'(16'(sp0 + 16'(n))));
            chk(rd_seen - r0 == n && wr_seen == w0, "R4/R2 read count", 64'(rd_seen - r0), 64'(n));
            chk(pull_data == (d & mask), "R4/R5 pulled value", pull_data, d & mask);
        end else begin
            chk(sp_out == 16'(sp0 - 16'(n)), "R3/R6 pointer after push", 64'(sp_out), 64'(16'(sp0 - 16'(n))));
            chk(wr_seen - w0 == n && rd_seen == r0, "R3/R2 write count", 64'(wr_seen - w0), 64'(n));
            got = '0;
            for (int i = 0; i < n; i++)
                got[8*(n-1-i) +: 8] = mem_rd(int'({bk, 16'(sp0 - 16'(i))}));
            chk(got == (d & mask), "R3 pushed bytes", got, d & mask);
        end
        chk(bank_err == b0, "R1 bank bits", 64'(bank_err - b0), 64'd0);
        @(negedge clk);
        chk(!done, "R7 done single cycle", 64'(done), 64'd0);
    endtask

    function automatic logic [15:0] sp_pick(input int p, input int s);
        case (p)
            0: return 16'h0000;
            1: return 16'h0003;
            2: return 16'hFFFE;
            default: return 16'(16'h8000 + s);
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; dir = 1'b0; size = '0; src_data = '0; bank = '0; sp_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        chk(!done && !mem_we && !mem_re, "R10 strobes after reset", {61'd0, done, mem_we, mem_re}, 64'd0);
        chk(sp_out == 16'd0 && pull_data == 64'd0, "R10 outputs after reset", pull_data | 64'(sp_out), 64'd0);

        for (int s = 0; s < 256; s++) begin
            for (int p = 0; p < 4; p++) begin
                logic [63:0] d;
                logic [15:0] sp0;
                logic [7:0]  bk;
                logic [7:0]  sz;
                // Alternate large and small sizes so stale upper bytes exist (R5)
                sz  = ((s + p) % 2 == 0) ? 8'(s) : 8'(255 - s);
                d   = 64'h0123_4567_89AB_CDEF ^ (64'(s) * 64'h9E37_79B9_7F4A_7C15) ^ 64'(p);
                sp0 = sp_pick(p, s);
                bk  = 8'(s ^ 8'h5A ^ p);
                run_op(1'b0, sz, d, bk, sp0, (s % 37) == 5);
                run_op(1'b1, sz, d, bk, 16'(sp0 - 16'(exp_len(sz))), (s % 41) == 7);
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule